// File: doc/BRIEF.md
# Frame-Clock Ratio Speed Selector

This block sits in the master-clock domain of an audio converter whose frame clock is driven from outside. It brings the external frame clock into the master-clock domain, counts master-clock cycles between consecutive rising frame edges, and sorts each count into one of three nominal ratios: 128, 256 or 512 master clocks per frame. Once the same nominal ratio has been seen twice in a row, it sets a speed-mode code and an internal divide-by-two select. No mode pins have to be set for this.

A count of 256 can mean two speed modes. A static preference input picks between them, with the slower mode as the default. Any count outside the accepted windows raises a flag and clears lock. A frame clock that stops has the same effect. In both cases the last good mode and divider are kept, so the downstream datapath is not disturbed.

Top module: `clk_ratio_speed_sel`

## Requirements
- R1: After a synchronous active-low reset the outputs are: `speed_mode` = 0, `div_half` = 0, `locked` = 0 and `unsupported` = 0. Speed codes are 0 = single, 1 = double and 2 = quad; code 3 never appears. `div_half` = 1 means divide by two.
- R2: Two consecutive frame periods measuring 128 cycles set `locked` = 1, `speed_mode` = 2 and `div_half` = 0.
- R3: Two consecutive periods measuring 512 cycles set `locked` = 1, `speed_mode` = 0 and `div_half` = 1.
- R4: Two consecutive periods measuring 256 cycles give one of two results. With `prefer_double` = 0 they give `speed_mode` = 0 and `div_half` = 0. With `prefer_double` = 1 they give `speed_mode` = 1 and `div_half` = 1. The preference is sampled when the locking period is measured.
- R5: A valid period whose nominal ratio differs from the previous measurement clears `locked`. It leaves `speed_mode` and `div_half` unchanged until a second matching period confirms the new ratio.
- R6: A period outside every accepted window sets `unsupported` = 1 and clears `locked`, and `speed_mode` and `div_half` keep their values. The next valid period clears `unsupported`, but it cannot lock by itself.
- R7: A period is accepted if it lies within ±2 cycles of its nominal value. For the 128 ratio, 126 and 130 are accepted and 125 and 131 are rejected.
- R8: If no rising frame edge arrives for 2^CNT_W−1 master-clock cycles (1023 by default), the block sets `unsupported` = 1 and `locked` = 0. The period that ends at the next edge counts as out of range.
- R9: The first rising frame edge after reset only starts timing. Lock therefore needs at least three rising edges, which gives two measured periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | External frame clock, asynchronous to `clk` |
| prefer_double | input | 1 | Picks the mode for a ratio of 256: 0 = single, 1 = double |
| speed_mode | output | 2 | Selected speed: 0 single, 1 double, 2 quad |
| div_half | output | 1 | 1 = internal master clock divided by two |
| locked | output | 1 | Ratio confirmed by two matching periods |
| unsupported | output | 1 | Last period out of range, or frame clock stopped |

## Verification
The in-line properties check the following on every cycle:
- `locked` and `unsupported` are never high together.
- The speed code never takes the value 3.
- Quad speed never comes with the divider on.
- Mode and divider change only in the cycle after a measurement.
- Lock rises only after a measurement, and a stall always raises the flag.
- Synchronized edges and measurement strobes never occur on back-to-back cycles.

Some behaviours need multi-period scenarios, which only the bench's sequences can show:
- The two-period confirmation rule and the priming edge.
- The exact ±2 window boundaries.
- The tie-break at 256.
- Holding the last mode across bad periods.
- Recovery after a stopped frame clock.

// File: rtl/crs_pkg.sv
// Package crs_pkg
// Shared types and the ratio-to-setting mapping for the clock-ratio speed
// selector. Assumes the three nominal ratios are BASE, 2*BASE and 4*BASE.
package crs_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    typedef enum logic [1:0] {
        RAT_X1  = 2'd0,   // BASE (128 by default)
        RAT_X2  = 2'd1,   // 2*BASE
        RAT_X4  = 2'd2,   // 4*BASE
        RAT_BAD = 2'd3
    } ratio_e;

    // Speed mode for a confirmed ratio; pref_dbl breaks the 2*BASE tie.
    function automatic speed_e pick_speed(ratio_e r, logic pref_dbl);
        case (r)
            RAT_X1:  pick_speed = SPD_QUAD;
            RAT_X2:  pick_speed = pref_dbl ? SPD_DOUBLE : SPD_SINGLE;
            default: pick_speed = SPD_SINGLE;
        endcase
    endfunction

    // Divide-by-two select for a confirmed ratio.
    function automatic logic pick_div(ratio_e r, logic pref_dbl);
        case (r)
            RAT_X1:  pick_div = 1'b0;
            RAT_X2:  pick_div = pref_dbl;
            default: pick_div = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/crs_frame_sync.sv
// Module crs_frame_sync
// Brings the asynchronous frame clock into the master-clock domain with a
// two-flop synchronizer and emits a one-cycle pulse per rising edge.
// Assumes the frame clock stays high and low for at least two cycles each.
module crs_frame_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk,
    output logic rise_pulse
);
    logic meta_q, sync_q, hist_q;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= frame_clk;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign rise_pulse = sync_q & ~hist_q;

    // R9: a synchronized edge can never repeat on the next cycle
    p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/crs_period_meter.sv
// Module crs_period_meter
// Counts master-clock cycles between frame edges. At each edge after the
// first it strobes the count. It reports a stall while the saturating
// counter is at its ceiling. Assumes 4*BASE+TOL fits in CNT_W bits.
module crs_period_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_pulse,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_val,
    output logic             stall
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    // Saturating cycle counter, restarted at every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (rise_pulse)     cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end

    // The first edge only primes; later edges capture the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q   <= 1'b0;
            meas_valid <= 1'b0;
            meas_val   <= '0;
        end else begin
            meas_valid <= rise_pulse & primed_q;
            if (rise_pulse) begin
                primed_q <= 1'b1;
                meas_val <= cnt_q;
            end
        end
    end

    assign stall = (cnt_q == CNT_MAX);

    // R9: measurements are at least two cycles apart
    p_meas_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

endmodule

// File: rtl/crs_ratio_class.sv
// Module crs_ratio_class
// Sorts a measured period into one of three nominal ratios, each accepted
// within +/-TOL cycles, or marks it bad. The windows are built by a generate
// loop. Assumes the windows do not overlap.
module crs_ratio_class
    import crs_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int BASE  = 128,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0] meas_val,
    output ratio_e           ratio
);
    localparam int NRAT = 3;

    logic [NRAT-1:0] hit;

    for (genvar gi = 0; gi < NRAT; gi++) begin : g_win
        localparam logic [CNT_W-1:0] LO = CNT_W'((BASE << gi) - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'((BASE << gi) + TOL);
        assign hit[gi] = (meas_val >= LO) && (meas_val <= HI);
    end

    // One-hot window hits to ratio code.
    always_comb begin
        case (hit)
            3'b001:  ratio = RAT_X1;
            3'b010:  ratio = RAT_X2;
            3'b100:  ratio = RAT_X4;
            default: ratio = RAT_BAD;
        endcase
    end

    // R7: at most one window can match a period
    p_win_onehot_r7: assert property (@(meas_val) $onehot0(hit))
        else $error("overlapping ratio windows");

endmodule

// File: rtl/crs_mode_lock.sv
// Module crs_mode_lock
// Confirms a ratio over two matching measurements and drives the speed
// mode, divider, lock and unsupported outputs. It holds the last good mode
// through bad periods and stalls.
module crs_mode_lock
    import crs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   meas_valid,
    input  ratio_e ratio,
    input  logic   stall,
    input  logic   prefer_double,
    output speed_e speed_mode,
    output logic   div_half,
    output logic   locked,
    output logic   unsupported
);
    ratio_e prev_q;

    // Lock state machine: confirm, update, or drop on bad input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= RAT_BAD;
            speed_mode  <= SPD_SINGLE;
            div_half    <= 1'b0;
            locked      <= 1'b0;
            unsupported <= 1'b0;
        end else if (meas_valid) begin
            if (ratio == RAT_BAD) begin
                unsupported <= 1'b1;
                locked      <= 1'b0;
                prev_q      <= RAT_BAD;
            end else begin
                unsupported <= 1'b0;
                prev_q      <= ratio;
                if (ratio == prev_q) begin
                    locked     <= 1'b1;
                    speed_mode <= pick_speed(ratio, prefer_double);
                    div_half   <= pick_div(ratio, prefer_double);
                end else begin
                    locked     <= 1'b0;
                end
            end
        end else if (stall) begin
            unsupported <= 1'b1;
            locked      <= 1'b0;
            prev_q      <= RAT_BAD;
        end
    end

    // R6: lock and unsupported are exclusive
    p_lock_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> !locked);
    // R1: speed code 3 never appears
    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        speed_mode != 2'd3);
    // R2: quad speed never has the divider on
    p_quad_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_mode == SPD_QUAD) |-> !div_half);
    // R5: mode and divider move only after a measurement
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(meas_valid) |-> ($stable(speed_mode) && $stable(div_half)));
    // R9: lock rises only after a measurement
    p_lock_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_valid));
    // R8: a stall with no measurement raises the flag
    p_stall_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !meas_valid) |=> unsupported);

endmodule

// File: rtl/clk_ratio_speed_sel.sv
// Module clk_ratio_speed_sel (top)
// Picks the speed mode and internal divider from the measured master-clock
// to frame-clock ratio. Chain: synchronizer -> period meter -> ratio
// classifier -> lock stage. Assumes the frame clock is driven from outside.
module clk_ratio_speed_sel
    import crs_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int BASE  = 128,
    parameter int TOL   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       prefer_double,
    output logic [1:0] speed_mode,
    output logic       div_half,
    output logic       locked,
    output logic       unsupported
);
    logic             rise_pulse;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_val;
    logic             stall;
    ratio_e           ratio;
    speed_e           speed_q;

    crs_frame_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .rise_pulse (rise_pulse)
    );

    crs_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_pulse (rise_pulse),
        .meas_valid (meas_valid),
        .meas_val   (meas_val),
        .stall      (stall)
    );

    crs_ratio_class #(.CNT_W(CNT_W), .BASE(BASE), .TOL(TOL)) u_class (
        .meas_val (meas_val),
        .ratio    (ratio)
    );

    crs_mode_lock u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .meas_valid    (meas_valid),
        .ratio         (ratio),
        .stall         (stall),
        .prefer_double (prefer_double),
        .speed_mode    (speed_q),
        .div_half      (div_half),
        .locked        (locked),
        .unsupported   (unsupported)
    );

    assign speed_mode = speed_q;

endmodule

// File: tb/clk_ratio_speed_sel_bench.sv
module clk_ratio_speed_sel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       prefer_double = 1'b0;
    logic [1:0] speed_mode;
    logic       div_half, locked, unsupported;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    int m_prev, m_speed, m_div, m_lock, m_unsup, m_primed, since;

    always #4 clk = ~clk;

    clk_ratio_speed_sel u_clk_ratio_speed_sel (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .prefer_double(prefer_double), .speed_mode(speed_mode),
        .div_half(div_half), .locked(locked), .unsupported(unsupported)
    );

    function automatic int classify(int m);
        if (m >= 126 && m <= 130) return 0;
        if (m >= 254 && m <= 258) return 1;
        if (m >= 510 && m <= 514) return 2;
        return 3;
    endfunction

    // Applies one measured period to the reference model.
    function automatic void model_meas(int m, bit pref);
        int c;
        c = classify(m);
        if (c == 3) begin
            m_unsup = 1; m_lock = 0; m_prev = 3;
        end else begin
            m_unsup = 0;
            if (c == m_prev) begin
                m_lock = 1;
                m_speed = (c == 0) ? 2 : (c == 1 && pref) ? 1 : 0;
                m_div   = (c == 2) ? 1 : (c == 1 && pref) ? 1 : 0;
            end else m_lock = 0;
            m_prev = c;
        end
    endfunction

    task automatic chk(string req, int act, int exp_v, string what);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, speed_mode, m_speed, "speed_mode");
        chk(req, div_half, m_div, "div_half");
        chk(req, locked, m_lock, "locked");
        chk(req, unsupported, m_unsup, "unsupported");
    endtask

    // Drives n frame periods of p cycles each, back to back.
    task automatic frames(int p, int n);
        for (int k = 0; k < n; k++) begin
            if (m_primed != 0) model_meas(since, prefer_double);
            m_primed = 1;
            since = 0;
            frame_clk = 1'b1;
            for (int j = 0; j < p / 2; j++) begin @(negedge clk); since++; end
            frame_clk = 1'b0;
            for (int j = 0; j < p - p / 2; j++) begin @(negedge clk); since++; end
        end
    endtask

    // Holds the frame clock low for c cycles.
    task automatic idle(int c);
        for (int j = 0; j < c; j++) begin @(negedge clk); since++; end
        if (since > 1100) begin m_unsup = 1; m_lock = 0; m_prev = 3; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_prev = 3; m_speed = 0; m_div = 0; m_lock = 0; m_unsup = 0;
        m_primed = 0; since = 0;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", speed_mode, 0, "speed_mode");
        chk("R1", div_half, 0, "div_half");
        chk("R1", locked, 0, "locked");
        chk("R1", unsupported, 0, "unsupported");

        // R9: two edges give only one measurement
        frames(128, 2);
        chk("R9", locked, 0, "locked");
        // R2: quad lock
        frames(128, 1);
        chk("R2", locked, 1, "locked");
        chk("R2", speed_mode, 2, "speed_mode");
        chk("R2", div_half, 0, "div_half");
        // R3: single with divide by two
        frames(512, 3);
        chk("R3", speed_mode, 0, "speed_mode");
        chk("R3", div_half, 1, "div_half");
        chk("R3", locked, 1, "locked");
        // R4: tie-break at 256
        frames(256, 3);
        chk("R4", speed_mode, 0, "speed_mode");
        chk("R4", div_half, 0, "div_half");
        prefer_double = 1'b1;
        frames(256, 2);
        chk("R4", speed_mode, 1, "speed_mode");
        chk("R4", div_half, 1, "div_half");
        // R5: change of ratio drops lock but holds mode
        frames(128, 2);
        chk("R5", locked, 0, "locked");
        chk("R5", speed_mode, 1, "speed_mode");
        chk_all("R5");
        frames(128, 1);
        chk("R5", speed_mode, 2, "speed_mode");
        // R7 and R6: window edges
        frames(130, 3);
        chk("R7", locked, 1, "locked");
        frames(131, 2);
        chk("R7", unsupported, 1, "unsupported");
        chk("R6", speed_mode, 2, "speed_mode");
        frames(126, 2);
        chk("R6", locked, 0, "locked");
        chk("R6", unsupported, 0, "unsupported");
        frames(126, 1);
        chk("R7", locked, 1, "locked");
        frames(125, 2);
        chk("R7", unsupported, 1, "unsupported");
        frames(64, 3);
        chk("R6", unsupported, 1, "unsupported");
        chk_all("R6");
        // R8: stopped frame clock
        frames(128, 3);
        idle(1500);
        chk("R8", unsupported, 1, "unsupported");
        chk("R8", locked, 0, "locked");
        frames(512, 2);
        chk("R8", locked, 0, "locked");
        frames(512, 1);
        chk("R8", locked, 1, "locked");
        chk_all("R8");

        // Constrained random segments, checked against the model
        for (int s = 0; s < 25; s++) begin
            int sel, per, nom;
            sel = $urandom % 6;
            nom = 128 << ($urandom % 3);
            case (sel)
                0: per = 128;
                1: per = 256;
                2: per = 512;
                3: per = nom - 2 + int'($urandom % 5);
                4: per = 64 + int'($urandom % 537);
                default: per = 64;
            endcase
            prefer_double = 1'($urandom % 2);
            frames(per, 1 + int'($urandom % 4));
            chk_all("R6_random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule